// File: doc/BRIEF.md
# Lazy Vector Register Context Tracker

This block decides, at context-switch time, whether the vector register file has to be written out, and during execution, whether a vector register must be fetched back from memory before it can be read. It keeps one modified flag for the whole vector unit and one "present" bit per register. When a process is switched out and no vector register has been written since the last save, no save is requested. When a process starts, every register is marked absent. A register is brought back only when the first read of it arrives. A write to an absent register makes it present without any fetch, because its old contents are overwritten.

The block produces only control and handshake signals. The register data path and the engine that moves register contents to and from memory sit outside it. While a save or a restore handshake is open, the block raises a stall so that the surrounding pipeline holds its request. At most one handshake is open at any time.

Top module: `vctx_tracker`

## Requirements
- R1: After a synchronous reset, `save_req`, `restore_req` and `stall` are low, the modified flag is clear and every register is absent.
- R2: An accepted write sets the modified flag and marks register `wr_idx` present, so a later read of it raises no restore.
- R3: An accepted switch-out while the modified flag is clear raises neither `save_req` nor `stall`.
- R4: An accepted switch-out while the modified flag is set raises `save_req` and `stall` one cycle later. Both stay high until `save_ack` is sampled high, fall in the next cycle, and the modified flag is then clear.
- R5: An accepted read of an absent register raises `restore_req` and `stall` one cycle later, with `restore_idx` equal to `rd_idx`. These are held stable until `restore_ack` is sampled high, after which they fall and the register is present.
- R6: An accepted read of a present register raises no restore and no stall.
- R7: An accepted process start marks every register absent and leaves the modified flag unchanged.
- R8: While `stall` is high, `wr_en`, `rd_en`, `swout_req` and `proc_start` are ignored, and an acknowledge for the handshake that is not open is ignored. `save_req` and `restore_req` are never high together.
- R9: In one idle cycle `swout_req` wins over `proc_start`, and both win over reads and writes, which are then ignored. A read and a write to the same index in one cycle raise no restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Vector register write strobe |
| wr_idx | input | 4 | Index of the written register |
| rd_en | input | 1 | Vector register read request |
| rd_idx | input | 4 | Index of the read register |
| swout_req | input | 1 | Context switch-out command |
| proc_start | input | 1 | Process start command |
| save_ack | input | 1 | Save engine done |
| restore_ack | input | 1 | Restore of `restore_idx` done |
| save_req | output | 1 | Vector state must be saved |
| restore_req | output | 1 | Register `restore_idx` must be restored |
| restore_idx | output | 4 | Register to restore |
| stall | output | 1 | Hold the pipeline request |

## Verification
Directed sequences cover a switch-out with a clean unit and with a modified unit. They also cover a read of an absent register and of a present one, a process start followed by a read, and same-cycle collisions of commands. These separate a save that is correctly skipped from one that is lost, and a restore that is deferred from one that is never raised. A long seeded random run then mixes all commands with acknowledges that arrive early, late or for the wrong handshake. In every cycle it compares all outputs with a bench model, which exposes requests that are dropped or accepted during a stall.

// File: rtl/vctx_pkg.sv
package vctx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAVE = 2'd1,
    ST_REST = 2'd2
  } ctx_state_e;
endpackage

// File: rtl/vctx_valid_bits.sv
module vctx_valid_bits #(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             wr_set,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             rs_set,
  input  logic [IDX_W-1:0] rs_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid
);
  logic [NUM_REGS-1:0] vbits;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [IDX_W-1:0] KIDX = IDX_W'(g);
      always_ff @(posedge clk) begin
        if (rst || clr_all)
          vbits[g] <= 1'b0;
        else if ((wr_set && wr_idx == KIDX) || (rs_set && rs_idx == KIDX))
          vbits[g] <= 1'b1;
      end
    end
  endgenerate

  assign rd_valid = vbits[rd_idx];

  // R7
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (vbits == '0));
  // R5
  restore_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (rs_set && !clr_all) |=> vbits[$past(rs_idx)]);
endmodule

// File: rtl/vctx_dirty.sv
module vctx_dirty (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic dirty_q
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      dirty_q <= 1'b0;
    else if (set)
      dirty_q <= 1'b1;
  end

  // R2
  dirty_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set && !clr) |=> dirty_q);
endmodule

// File: rtl/vctx_fsm.sv
module vctx_fsm
  import vctx_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             swout_req,
  input  logic             proc_start,
  input  logic             save_ack,
  input  logic             restore_ack,
  input  logic             dirty,
  input  logic             rd_valid,
  output logic             do_wr,
  output logic             do_clr_all,
  output logic             do_rs_set,
  output logic             do_dirty_clr,
  output logic             save_req,
  output logic             restore_req,
  output logic [IDX_W-1:0] restore_idx,
  output logic             stall
);
  ctx_state_e state_q, state_d;
  logic       idle, start_save, start_rest, ops_ok;

  assign idle       = (state_q == ST_IDLE);
  assign ops_ok     = idle && !swout_req && !proc_start;
  assign start_save = idle && swout_req && dirty;
  assign do_clr_all = idle && !swout_req && proc_start;
  assign do_wr      = ops_ok && wr_en;
  assign start_rest = ops_ok && rd_en && !rd_valid &&
                      !(wr_en && (wr_idx == rd_idx));
  assign do_rs_set    = (state_q == ST_REST) && restore_ack;
  assign do_dirty_clr = (state_q == ST_SAVE) && save_ack;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (start_save)      state_d = ST_SAVE;
        else if (start_rest) state_d = ST_REST;
      end
      ST_SAVE: if (save_ack)    state_d = ST_IDLE;
      ST_REST: if (restore_ack) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      save_req    <= 1'b0;
      restore_req <= 1'b0;
      stall       <= 1'b0;
      restore_idx <= '0;
    end else begin
      state_q     <= state_d;
      save_req    <= (state_d == ST_SAVE);
      restore_req <= (state_d == ST_REST);
      stall       <= (state_d != ST_IDLE);
      if (start_rest) restore_idx <= rd_idx;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!stall && !save_req && !restore_req));
  // R8
  one_req_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({save_req, restore_req}));
  // R4
  save_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (save_req && !save_ack) |=> (save_req && stall));
  // R4
  save_done_chk: assert property (@(posedge clk) disable iff (rst)
    (save_req && save_ack) |=> (!save_req && !stall));
  // R5
  restore_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (restore_req && !restore_ack) |=> (restore_req && $stable(restore_idx)));
  // R3
  clean_swout_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && swout_req && !dirty) |=> (!save_req && !stall));
endmodule

// File: rtl/vctx_tracker.sv
module vctx_tracker #(
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             swout_req,
  input  logic             proc_start,
  input  logic             save_ack,
  input  logic             restore_ack,
  output logic             save_req,
  output logic             restore_req,
  output logic [IDX_W-1:0] restore_idx,
  output logic             stall
);
  logic dirty, rd_valid, do_wr, do_clr_all, do_rs_set, do_dirty_clr;

  vctx_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .rd_en(rd_en), .rd_idx(rd_idx),
    .swout_req(swout_req), .proc_start(proc_start),
    .save_ack(save_ack), .restore_ack(restore_ack),
    .dirty(dirty), .rd_valid(rd_valid),
    .do_wr(do_wr), .do_clr_all(do_clr_all), .do_rs_set(do_rs_set),
    .do_dirty_clr(do_dirty_clr),
    .save_req(save_req), .restore_req(restore_req),
    .restore_idx(restore_idx), .stall(stall)
  );

  vctx_dirty u_dirty (
    .clk(clk), .rst(rst), .set(do_wr), .clr(do_dirty_clr), .dirty_q(dirty)
  );

  vctx_valid_bits #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_valid (
    .clk(clk), .rst(rst), .clr_all(do_clr_all),
    .wr_set(do_wr), .wr_idx(wr_idx),
    .rs_set(do_rs_set), .rs_idx(restore_idx),
    .rd_idx(rd_idx), .rd_valid(rd_valid)
  );
endmodule

// File: tb/vctx_tracker_tb.sv
module vctx_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, rd_en = 0, swout_req = 0, proc_start = 0;
  logic save_ack = 0, restore_ack = 0;
  logic [3:0] wr_idx = 0, rd_idx = 0;
  logic save_req, restore_req, stall;
  logic [3:0] restore_idx;

  int checks = 0, errors = 0;
  bit done = 0;

  bit m_sv, m_rs, m_dirty;
  bit [3:0] m_idx;
  bit [NREG-1:0] m_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  vctx_tracker u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .rd_en(rd_en), .rd_idx(rd_idx), .swout_req(swout_req),
    .proc_start(proc_start), .save_ack(save_ack), .restore_ack(restore_ack),
    .save_req(save_req), .restore_req(restore_req),
    .restore_idx(restore_idx), .stall(stall)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (m_sv) begin
      if (save_ack) begin m_sv = 0; m_dirty = 0; end
    end else if (m_rs) begin
      if (restore_ack) begin m_valid[m_idx] = 1; m_rs = 0; end
    end else if (swout_req) begin
      if (m_dirty) m_sv = 1;
    end else if (proc_start) begin
      m_valid = '0;
    end else begin
      bit [NREG-1:0] old = m_valid;
      if (wr_en) begin m_valid[wr_idx] = 1; m_dirty = 1; end
      if (rd_en && !old[rd_idx] && !(wr_en && wr_idx == rd_idx)) begin
        m_rs = 1; m_idx = rd_idx;
      end
    end
  endtask

  task automatic cmp_model();
    chk({7'd0, save_req},    {7'd0, m_sv},        "R4 save_req");
    chk({7'd0, restore_req}, {7'd0, m_rs},        "R5 restore_req");
    chk({7'd0, stall},       {7'd0, m_sv | m_rs}, "R8 stall");
    if (m_rs) chk({4'd0, restore_idx}, {4'd0, m_idx}, "R5 restore_idx");
  endtask

  // apply one cycle of inputs, clock, update model, compare
  task automatic step(input bit w, input bit [3:0] wi, input bit r, input bit [3:0] ri,
                      input bit so, input bit ps, input bit sa, input bit ra);
    wr_en = w; wr_idx = wi; rd_en = r; rd_idx = ri;
    swout_req = so; proc_start = ps; save_ack = sa; restore_ack = ra;
    @(posedge clk);
    model_edge();
    #1;
    cmp_model();
  endtask

  task automatic idle_step();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    m_sv = 0; m_rs = 0; m_dirty = 0; m_idx = 0; m_valid = '0;
    // R1: idle outputs after reset
    chk({7'd0, stall}, 8'd0, "R1 stall");
    chk({7'd0, save_req}, 8'd0, "R1 save_req");
    chk({7'd0, restore_req}, 8'd0, "R1 restore_req");

    // R3: clean switch-out skips save
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk({7'd0, save_req}, 8'd0, "R3 save_req");
    chk({7'd0, stall}, 8'd0, "R3 stall");

    // R1/R5: read of absent reg 5 raises restore
    step(0, 0, 1, 5, 0, 0, 0, 0);
    chk({7'd0, restore_req}, 8'd1, "R5 restore_req");
    chk({4'd0, restore_idx}, 8'd5, "R5 restore_idx");
    chk({7'd0, stall}, 8'd1, "R5 stall");
    // R8: commands and wrong ack during stall are ignored
    step(1, 7, 1, 9, 1, 1, 1, 0);
    chk({7'd0, restore_req}, 8'd1, "R8 restore held");
    chk({7'd0, save_req}, 8'd0, "R8 no save");
    step(0, 0, 0, 0, 0, 0, 0, 1);
    chk({7'd0, restore_req}, 8'd0, "R5 restore done");
    chk({7'd0, stall}, 8'd0, "R5 stall drop");
    // R6: reg 5 now present
    step(0, 0, 1, 5, 0, 0, 0, 0);
    chk({7'd0, restore_req}, 8'd0, "R6 no restore");
    chk({7'd0, stall}, 8'd0, "R6 no stall");
    // R8: write to 7 was ignored so unit still clean
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk({7'd0, save_req}, 8'd0, "R8 write ignored");

    // R2: write to 3 sets present and modified
    step(1, 3, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 3, 0, 0, 0, 0);
    chk({7'd0, restore_req}, 8'd0, "R2 no restore");
    // R4: modified switch-out saves
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk({7'd0, save_req}, 8'd1, "R4 save_req");
    chk({7'd0, stall}, 8'd1, "R4 stall");
    step(0, 0, 0, 0, 0, 0, 0, 1);
    chk({7'd0, save_req}, 8'd1, "R8 wrong ack ignored");
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk({7'd0, save_req}, 8'd0, "R4 save done");
    chk({7'd0, stall}, 8'd0, "R4 stall drop");
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk({7'd0, save_req}, 8'd0, "R4 dirty cleared");

    // R7: process start clears present bits, keeps modified flag
    step(1, 8, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 1, 3, 0, 0, 0, 0);
    chk({7'd0, restore_req}, 8'd1, "R7 restore after start");
    chk({4'd0, restore_idx}, 8'd3, "R7 restore_idx");
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk({7'd0, save_req}, 8'd1, "R7 dirty kept");
    step(0, 0, 0, 0, 0, 0, 1, 0);

    // R9: swout wins over write (unit clean)
    step(1, 2, 0, 0, 1, 0, 0, 0);
    chk({7'd0, save_req}, 8'd0, "R9 swout over write");
    step(0, 0, 1, 2, 0, 0, 0, 0);
    chk({7'd0, restore_req}, 8'd1, "R9 write ignored");
    step(0, 0, 0, 0, 0, 0, 0, 1);
    // R9: proc_start wins over read
    step(0, 0, 1, 11, 0, 1, 0, 0);
    chk({7'd0, restore_req}, 8'd0, "R9 start over read");
    // R9: same-index read and write
    step(1, 4, 1, 4, 0, 0, 0, 0);
    chk({7'd0, restore_req}, 8'd0, "R9 same index");
    step(0, 0, 1, 4, 0, 0, 0, 0);
    chk({7'd0, restore_req}, 8'd0, "R9 reg present");

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = $urandom;
      step(r[0] & r[1], 4'($urandom % NREG), r[2] & r[3], 4'($urandom % NREG),
           (r[7:4] == 4'd0), (r[11:8] == 4'd0), r[12] & r[13], r[14] & r[15]);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule